// File: doc/BRIEF.md
# Dual-Reference Clock-Enable Divider

This block makes a divided clock-enable for one peripheral domain from one of two reference clocks. The references are a slow crystal reference and a faster synthesized reference. Each reference has its own integer divider and its own divider counter, and both counters run in the domain of their own reference. A bypass select chooses which reference drives the output. When bypass is set, the enable comes from the crystal side (`xtal_ce`). When bypass is clear, it comes from the fast side (`fref_ce`). The enable of the reference that is not selected stays low.

Divider values, the bypass select and a sync-mode enable are written from a configuration clock domain. A new divider value goes to its reference domain through a toggle-request / acknowledge handshake, with two-flop synchronizers in each direction. On the configuration side, each handshake is a two-state machine. `HS_IDLE` moves to `HS_WAIT` when a transfer starts. `HS_WAIT` moves back to `HS_IDLE` when the synchronized acknowledge equals the request toggle. The busy flag reads 1 in `HS_WAIT`.

On the reference side, each divider has its own two-state machine. `DV_STEADY` moves to `DV_ARMED` when a new value has been captured. `DV_ARMED` moves back to `DV_STEADY` at the next terminal count, which is where the captured value becomes the active divisor. A third handshake is the resync channel. It answers from the crystal domain and tracks changes to the sync-mode enable, and changes to bypass made while sync mode is on.

Top module: `dualref_clkdiv`

## Requirements
- R1: After reset both divisors are 1, bypass is 1, sync mode is 0, all busy flags are 0 and `wr_err` is 0. So `xtal_ce` is high on every crystal cycle and `fref_ce` stays low.
- R2: With bypass at 1, only `xtal_ce` pulses. With bypass at 0, only `fref_ce` pulses.
- R3: With a crystal divisor N (1..15), `xtal_ce` pulses exactly once every N crystal cycles.
- R4: With a fast-reference divisor M (1..63), `fref_ce` pulses exactly once every M fast-reference cycles.
- R5: A zero in a divider field is ignored. That divisor keeps its previous value, and its busy flag does not rise.
- R6: An accepted write with a nonzero divider field raises that field's busy flag at the next configuration clock edge. The flag stays high until the acknowledge comes back from the reference domain.
- R7: While the fast reference clock is stopped, `busy_fref` stays high after a write to its field. The flag clears only after that clock runs again.
- R8: `busy_resync` rises at the edge after an accepted write that changes the sync enable, or that changes bypass while sync mode is 1. A bypass change made with sync mode at 0 leaves it low.
- R9: A write while any busy flag is high is dropped. None of the stored settings change, and the sticky `wr_err` becomes 1 and stays 1 until reset.
- R10: A new divisor takes effect only at a terminal count. Every gap between enable pulses equals either the old divisor or the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, shared by all domains |
| wr_en | input | 1 | Write strobe, sampled on cfg_clk |
| wr_xdiv | input | 4 | Crystal divisor; 0 means keep the current value |
| wr_fdiv | input | 6 | Fast-reference divisor; 0 means keep the current value |
| wr_bypass | input | 1 | 1 selects the crystal reference |
| wr_sync | input | 1 | Sync-mode enable |
| busy_xtal | output | 1 | Crystal divisor transfer in flight |
| busy_fref | output | 1 | Fast-reference divisor transfer in flight |
| busy_resync | output | 1 | Mode/bypass resync in flight |
| wr_err | output | 1 | Sticky flag for a write that was dropped |
| xtal_clk | input | 1 | Crystal reference clock |
| xtal_ce | output | 1 | Divided enable in the xtal_clk domain |
| fref_clk | input | 1 | Fast reference clock |
| fref_ce | output | 1 | Divided enable in the fref_clk domain |

## Verification
The busy flags and `wr_err` are due at the first `cfg_clk` rising edge after the write. The bench reads them on the falling edge that follows. A divider update arrives after a round trip of about two reference cycles plus three configuration cycles. The bench therefore polls the busy flags with a bounded wait instead of assuming a fixed latency. Divider results are checked on falling reference edges as the spacing between consecutive enable pulses. The first pulse after a measurement window opens only arms the count, so a partial period is never judged.

// File: rtl/dualref_pkg.sv
package dualref_pkg;
    typedef enum logic {HS_IDLE, HS_WAIT} hs_state_t;
    typedef enum logic {DV_STEADY, DV_ARMED} dv_state_t;
endpackage

// File: rtl/dualref_sync2.sv
module dualref_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/dualref_hs_sender.sv
module dualref_hs_sender
    import dualref_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ack_tgl,
    output logic req_tgl,
    output logic busy
);
    hs_state_t state_q, state_d;
    logic      req_q;
    logic      ack_s;

    dualref_sync2 u_ack_sync (.clk(clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: if (start) state_d = HS_WAIT;
            HS_WAIT: if (ack_s == req_q) state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start && state_q == HS_IDLE) req_q <= ~req_q;
        end
    end

    assign req_tgl = req_q;
    assign busy    = (state_q == HS_WAIT);

    // R6: a started transfer shows busy at the next edge
    a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == HS_IDLE) |=> busy);
    // R6: busy holds until the acknowledge has returned
    a_r6_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ack_s != req_q) |=> busy);
endmodule

// File: rtl/dualref_div_engine.sv
module dualref_div_engine
    import dualref_pkg::*;
#(
    parameter int W        = 4,
    parameter bit SEL_HIGH = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_tgl,
    input  logic [W-1:0] div_in,
    input  logic         sel,
    output logic         ce,
    output logic         ack_tgl
);
    localparam logic [W-1:0] ONE = W'(1);

    dv_state_t    st_q, st_d;
    logic         req_s, req_d;
    logic         sel_s;
    logic         new_req;
    logic         tick;
    logic [W-1:0] pend_q, act_q, cnt_q;

    dualref_sync2 u_req_sync (.clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_s));
    dualref_sync2 u_sel_sync (.clk(clk), .rst_n(rst_n), .d(sel),     .q(sel_s));

    assign new_req = req_s ^ req_d;
    assign tick    = (cnt_q == act_q - ONE);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DV_STEADY: if (new_req) st_d = DV_ARMED;
            DV_ARMED:  if (tick && !new_req) st_d = DV_STEADY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= DV_STEADY;
            req_d  <= 1'b0;
            pend_q <= ONE;
            act_q  <= ONE;
            cnt_q  <= '0;
        end else begin
            st_q  <= st_d;
            req_d <= req_s;
            if (new_req && div_in != '0) pend_q <= div_in;
            if (tick && st_q == DV_ARMED) act_q <= pend_q;
            cnt_q <= tick ? '0 : cnt_q + ONE;
        end
    end

    assign ce      = tick && (sel_s == SEL_HIGH);
    assign ack_tgl = req_d;

    // R3: the active divisor is never zero
    a_r3_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        act_q != '0);
    // R4: the counter stays inside the active period
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < act_q);
    // R10: the divisor only switches right after a terminal count
    a_r10_apply_at_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != $past(act_q)) |-> $past(tick));
endmodule

// File: rtl/dualref_clkdiv.sv
module dualref_clkdiv
    import dualref_pkg::*;
#(
    parameter int XW = 4,
    parameter int FW = 6
) (
    input  logic          cfg_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [XW-1:0] wr_xdiv,
    input  logic [FW-1:0] wr_fdiv,
    input  logic          wr_bypass,
    input  logic          wr_sync,
    output logic          busy_xtal,
    output logic          busy_fref,
    output logic          busy_resync,
    output logic          wr_err,
    input  logic          xtal_clk,
    output logic          xtal_ce,
    input  logic          fref_clk,
    output logic          fref_ce
);
    logic [XW-1:0] xdiv_q;
    logic [FW-1:0] fdiv_q;
    logic          byp_q, sync_q, err_q;
    logic          any_busy, accept;
    logic          start_x, start_f, start_rs;
    logic          req_x, req_f, req_rs;
    logic          ack_x, ack_f, ack_rs;

    assign any_busy = busy_xtal | busy_fref | busy_resync;
    assign accept   = wr_en & ~any_busy;
    assign start_x  = accept & (wr_xdiv != '0);
    assign start_f  = accept & (wr_fdiv != '0);
    assign start_rs = accept & ((wr_sync != sync_q) | (sync_q & (wr_bypass != byp_q)));

    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) begin
            xdiv_q <= XW'(1);
            fdiv_q <= FW'(1);
            byp_q  <= 1'b1;
            sync_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (start_x) xdiv_q <= wr_xdiv;
            if (start_f) fdiv_q <= wr_fdiv;
            if (accept) begin
                byp_q  <= wr_bypass;
                sync_q <= wr_sync;
            end
            if (wr_en && any_busy) err_q <= 1'b1;
        end
    end

    assign wr_err = err_q;

    dualref_hs_sender u_hs_x (.clk(cfg_clk), .rst_n(rst_n), .start(start_x),
                              .ack_tgl(ack_x), .req_tgl(req_x), .busy(busy_xtal));
    dualref_hs_sender u_hs_f (.clk(cfg_clk), .rst_n(rst_n), .start(start_f),
                              .ack_tgl(ack_f), .req_tgl(req_f), .busy(busy_fref));
    dualref_hs_sender u_hs_rs (.clk(cfg_clk), .rst_n(rst_n), .start(start_rs),
                               .ack_tgl(ack_rs), .req_tgl(req_rs), .busy(busy_resync));

    dualref_sync2 u_rs_echo (.clk(xtal_clk), .rst_n(rst_n), .d(req_rs), .q(ack_rs));

    dualref_div_engine #(.W(XW), .SEL_HIGH(1'b1)) u_xdiv (
        .clk(xtal_clk), .rst_n(rst_n), .req_tgl(req_x), .div_in(xdiv_q),
        .sel(byp_q), .ce(xtal_ce), .ack_tgl(ack_x));

    dualref_div_engine #(.W(FW), .SEL_HIGH(1'b0)) u_fdiv (
        .clk(fref_clk), .rst_n(rst_n), .req_tgl(req_f), .div_in(fdiv_q),
        .sel(byp_q), .ce(fref_ce), .ack_tgl(ack_f));

    // R9: a write during busy flags the error
    a_r9_err_set: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (wr_en && any_busy) |=> wr_err);
    // R9: a dropped write leaves all settings untouched
    a_r9_drop_hold: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (wr_en && any_busy) |=> ($stable(xdiv_q) && $stable(fdiv_q) && $stable(byp_q) && $stable(sync_q)));
    // R5: a zero divider field keeps the stored value
    a_r5_zero_keep: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (wr_en && wr_xdiv == '0 && wr_fdiv == '0) |=> ($stable(xdiv_q) && $stable(fdiv_q)));
    // R8: a sync-enable change starts a resync
    a_r8_resync: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (accept && wr_sync != sync_q) |=> busy_resync);
endmodule

// File: tb/test_dualref_clkdiv.sv
module test_dualref_clkdiv;
    logic       cclk = 1'b0, xclk = 1'b0, fclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_xdiv = '0;
    logic [5:0] wr_fdiv = '0;
    logic       wr_bypass = 1'b1, wr_sync = 1'b0;
    logic       busy_xtal, busy_fref, busy_resync, wr_err, xtal_ce, fref_ce;
    bit         f_run = 1'b1;
    bit         done = 1'b0;
    int         total = 0, bad = 0;

    always #2.5 cclk = ~cclk;
    always #7   xclk = ~xclk;
    initial forever begin
        #3;
        if (f_run) fclk = ~fclk;
    end

    dualref_clkdiv i_dualref_clkdiv (
        .cfg_clk(cclk), .rst_n(rst_n), .wr_en(wr_en), .wr_xdiv(wr_xdiv),
        .wr_fdiv(wr_fdiv), .wr_bypass(wr_bypass), .wr_sync(wr_sync),
        .busy_xtal(busy_xtal), .busy_fref(busy_fref), .busy_resync(busy_resync),
        .wr_err(wr_err), .xtal_clk(xclk), .xtal_ce(xtal_ce),
        .fref_clk(fclk), .fref_ce(fref_ce));

    // pulse-gap monitors, one per reference domain
    bit x_clr, x_armed; int x_since, x_cnt, x_odd, x_tot, x_last, x_ea, x_eb;
    bit f_clr, f_armed; int f_since, f_cnt, f_odd, f_tot, f_last, f_ea, f_eb;

    always @(negedge xclk) begin
        if (x_clr) begin
            x_clr = 0; x_armed = 0; x_since = 0; x_cnt = 0; x_odd = 0; x_tot = 0; x_last = 0;
        end else begin
            x_since++;
            if (xtal_ce) begin
                x_tot++;
                if (x_armed) begin
                    x_last = x_since; x_cnt++;
                    if (x_since != x_ea && x_since != x_eb) x_odd++;
                end
                x_armed = 1; x_since = 0;
            end
        end
    end

    always @(negedge fclk) begin
        if (f_clr) begin
            f_clr = 0; f_armed = 0; f_since = 0; f_cnt = 0; f_odd = 0; f_tot = 0; f_last = 0;
        end else begin
            f_since++;
            if (fref_ce) begin
                f_tot++;
                if (f_armed) begin
                    f_last = f_since; f_cnt++;
                    if (f_since != f_ea && f_since != f_eb) f_odd++;
                end
                f_armed = 1; f_since = 0;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write(int x, int f, bit byp, bit sy);
        @(negedge cclk);
        wr_en = 1'b1; wr_xdiv = 4'(x); wr_fdiv = 6'(f); wr_bypass = byp; wr_sync = sy;
        @(negedge cclk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(string tag);
        int n = 0;
        while ((busy_xtal || busy_fref || busy_resync) && n < 2000) begin
            @(negedge cclk);
            n++;
        end
        chk({tag, " busy cleared"}, int'(busy_xtal | busy_fref | busy_resync), 0);
    endtask

    task automatic meas_x(int ea, int eb, int cycles);
        x_ea = ea; x_eb = eb; x_clr = 1;
        repeat (cycles) @(negedge xclk);
    endtask

    task automatic meas_f(int ea, int eb, int cycles);
        f_ea = ea; f_eb = eb; f_clr = 1;
        repeat (cycles) @(negedge fclk);
    endtask

    task automatic t_reset();
        chk("R1 busy_xtal", int'(busy_xtal), 0);
        chk("R1 busy_fref", int'(busy_fref), 0);
        chk("R1 busy_resync", int'(busy_resync), 0);
        chk("R1 wr_err", int'(wr_err), 0);
        meas_x(1, 1, 20);
        meas_f(1, 1, 20);
        chk("R1 xtal gap 1", x_last, 1);
        chk("R1 xtal odd gaps", x_odd, 0);
        chk("R2 fref idle under bypass", f_tot, 0);
    endtask

    task automatic t_xdiv();
        write(5, 0, 1'b1, 1'b0);
        chk("R6 busy_xtal raised", int'(busy_xtal), 1);
        chk("R5 busy_fref stays low", int'(busy_fref), 0);
        wait_idle("R6");
        meas_x(5, 5, 60);
        chk("R3 xtal gap 5", x_last, 5);
        chk("R3 xtal odd gaps", x_odd, 0);
    endtask

    task automatic t_drop();
        write(3, 0, 1'b1, 1'b0);
        write(9, 0, 1'b1, 1'b0);
        chk("R9 wr_err set", int'(wr_err), 1);
        wait_idle("R9");
        meas_x(3, 3, 40);
        chk("R9 dropped value not applied", x_last, 3);
        chk("R9 odd gaps", x_odd, 0);
    endtask

    task automatic t_fsel();
        write(0, 7, 1'b0, 1'b0);
        wait_idle("R4");
        meas_f(7, 7, 80);
        meas_x(1, 1, 20);
        chk("R4 fref gap 7", f_last, 7);
        chk("R4 fref odd gaps", f_odd, 0);
        chk("R2 xtal idle without bypass", x_tot, 0);
    endtask

    task automatic t_zero();
        write(0, 0, 1'b0, 1'b0);
        chk("R5 busy_xtal low on zero", int'(busy_xtal), 0);
        chk("R5 busy_fref low on zero", int'(busy_fref), 0);
        meas_f(7, 7, 60);
        chk("R5 fref gap kept 7", f_last, 7);
    endtask

    task automatic t_switch();
        meas_f(7, 2, 5);
        write(0, 2, 1'b0, 1'b0);
        wait_idle("R10");
        repeat (40) @(negedge fclk);
        chk("R10 gaps only old or new", f_odd, 0);
        chk("R10 final gap 2", f_last, 2);
    endtask

    task automatic t_stop();
        f_run = 0;
        repeat (10) @(negedge cclk);
        write(0, 3, 1'b0, 1'b0);
        repeat (100) @(negedge cclk);
        chk("R7 busy_fref held while stopped", int'(busy_fref), 1);
        f_run = 1;
        wait_idle("R7");
        meas_f(3, 3, 40);
        chk("R7 fref gap 3 after restart", f_last, 3);
    endtask

    task automatic t_resync();
        write(0, 0, 1'b1, 1'b0);
        chk("R8 bypass change without sync", int'(busy_resync), 0);
        wait_idle("R8a");
        write(0, 0, 1'b1, 1'b1);
        chk("R8 sync change", int'(busy_resync), 1);
        wait_idle("R8b");
        write(0, 0, 1'b0, 1'b1);
        chk("R8 bypass change with sync", int'(busy_resync), 1);
        wait_idle("R8c");
        chk("R9 wr_err sticky", int'(wr_err), 1);
    endtask

    initial begin
        x_ea = 1; x_eb = 1; f_ea = 1; f_eb = 1;
        repeat (4) @(negedge cclk);
        rst_n = 1'b1;
        repeat (4) @(negedge cclk);
        t_reset();
        t_xdiv();
        t_drop();
        t_fsel();
        t_zero();
        t_switch();
        t_stop();
        t_resync();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule